// File: doc/BRIEF.md
# Asynchronous Memory Write Strobe Sequencer

This block runs one write access at a time on an asynchronous external memory bus and drives the control strobes for it. Its clock runs at twice the bus-clock rate, so one tick is half a bus period and the strobe edges can be placed at half-period offsets. The host loads a request in one cycle. The request carries an address, write data, a wait-state count, an extension mode and a hold-cycle option. The block then sequences chip select, the write strobe, the address and the data bus with its output enable.

The write pulse can be stretched in three ways. A programmed wait-state count stretches it by a fixed amount. An external acknowledge input stretches it for as long as the device holds that input low. The third mode applies both at once. The acknowledge input passes through a two-flop synchronizer and is judged only at bus-clock rising edges. Once acknowledge is seen high, the strobe stays low for two more bus periods. A hold option keeps the data driven for one extra bus period after the strobe rises.

Top module: `wr_strobe_seq`

## Requirements
- R1: After reset, mem_cs_n and mem_we_n are 1, mem_doe and done are 0, and ready is 1.
- R2: A request is taken only when req is high in a tick where ready is 1. Ready stays 0 from the next tick until the access ends. A req raised while ready is 0 has no effect on the access in progress, and no access follows from it.
- R3: mem_cs_n falls, and mem_addr carries the request address, one tick before mem_we_n falls. The address holds steady as long as mem_cs_n is low.
- R4: In mode 0 (wait states only), mem_we_n stays low for exactly 2*(1+W) ticks, where W is the 3-bit wait count from 0 to 7.
- R5: In mode 1 (acknowledge only) and in modes 2 and 3 (wait states plus acknowledge), the strobe ticks are numbered from 0. The synchronized acknowledge is the ack input as sampled two clock edges earlier. It is examined only in even strobe ticks. Let e be the first even tick in which it reads 1. The strobe then lasts max(M, e+4) ticks. M is 2 in mode 1 and 2*(1+W) in modes 2 and 3.
- R6: When mem_we_n rises, mem_cs_n and mem_addr stay as they are for one tick, and mem_cs_n then rises.
- R7: mem_doe rises in the same tick that mem_we_n falls, and stays high with the request data on mem_dout for the whole strobe.
- R8: With hold option 0, mem_doe falls in the tick mem_we_n rises. With hold option 1, mem_doe stays high for two more ticks after mem_we_n rises.
- R9: done is a one-tick pulse in the last busy tick of the access, and ready is 1 in the tick that follows.
- R10: Between the rise of mem_we_n and the next fall, mem_we_n stays high for at least two ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bus-clock rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Request strobe, taken while ready is high |
| req_addr | input | AW | Write address |
| req_data | input | DW | Write data |
| req_wait | input | WSW | Wait-state count W |
| req_mode | input | 2 | 0 wait states, 1 acknowledge, 2/3 both |
| req_hold | input | 1 | Extra data hold of one bus period |
| ready | output | 1 | Idle and able to take a request |
| ack | input | 1 | Asynchronous acknowledge from the device, low means wait |
| done | output | 1 | Pulse in the final tick of an access |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_addr | output | AW | Address bus |
| mem_dout | output | DW | Write data bus |
| mem_doe | output | 1 | Data bus output enable |

## Verification
The bench builds the block with its default widths: 16-bit address and data and a 3-bit wait count. With a 3-bit count the test can reach both ends of the wait range, 0 and 7, and the strobe-tick counter only has to count up to a 16-tick minimum. The test covers every mode code. It holds acknowledge low past the minimum pulse, releases it before the minimum, raises it on an odd strobe tick, and issues requests back to back and while the block is busy.

// File: rtl/wr_strobe_seq.sv
module wr_strobe_seq #(
  parameter int AW  = 16,
  parameter int DW  = 16,
  parameter int WSW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req,
  input  logic [AW-1:0]  req_addr,
  input  logic [DW-1:0]  req_data,
  input  logic [WSW-1:0] req_wait,
  input  logic [1:0]     req_mode,
  input  logic           req_hold,
  output logic           ready,
  input  logic           ack,
  output logic           done,
  output logic           mem_cs_n,
  output logic           mem_we_n,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_dout,
  output logic           mem_doe
);
  localparam int TW = WSW + 2;

  typedef enum logic [2:0] {IDLE, SETUP, STRB, RECOV, HOLDC} st_t;
  st_t st;

  logic [AW-1:0]  a_q;
  logic [DW-1:0]  d_q;
  logic [WSW-1:0] w_q;
  logic [1:0]     m_q;
  logic           h_q;
  logic           ack_m, ack_s;
  logic [TW-1:0]  tk;
  logic           ph, seen;
  logic [1:0]     asc;

  wire           ack_mode = (m_q != 2'd0);
  wire [WSW-1:0] wsel     = (m_q == 2'd1) ? '0 : w_q;
  wire [TW:0]    min_len  = {2'b00, wsel, 1'b0} + {{(TW-1){1'b0}}, 2'b10};
  wire [TW:0]    tk_n     = {1'b0, tk} + {{TW{1'b0}}, 1'b1};
  wire           last     = (tk_n >= min_len) && (!ack_mode || (seen && asc == 2'd3));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_m <= 1'b0;
      ack_s <= 1'b0;
    end else begin
      ack_m <= ack;
      ack_s <= ack_m;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= IDLE;
      a_q  <= '0;
      d_q  <= '0;
      w_q  <= '0;
      m_q  <= '0;
      h_q  <= 1'b0;
      tk   <= '0;
      ph   <= 1'b0;
      seen <= 1'b0;
      asc  <= '0;
    end else begin
      case (st)
        IDLE: if (req) begin
          a_q <= req_addr;
          d_q <= req_data;
          w_q <= req_wait;
          m_q <= req_mode;
          h_q <= req_hold;
          st  <= SETUP;
        end
        SETUP: begin
          tk   <= '0;
          ph   <= 1'b0;
          seen <= 1'b0;
          asc  <= '0;
          st   <= STRB;
        end
        STRB: begin
          ph <= ~ph;
          if (tk != '1) tk <= tk + {{(TW-1){1'b0}}, 1'b1};
          if (!seen && !ph && ack_s) begin
            seen <= 1'b1;
            asc  <= 2'd1;
          end else if (seen && asc != 2'd3) begin
            asc <= asc + 2'd1;
          end
          if (last) st <= RECOV;
        end
        RECOV:   st <= h_q ? HOLDC : IDLE;
        default: st <= IDLE;
      endcase
    end
  end

  assign ready    = (st == IDLE);
  assign mem_cs_n = !(st == SETUP || st == STRB || st == RECOV);
  assign mem_we_n = (st != STRB);
  assign mem_doe  = (st == STRB) || (h_q && (st == RECOV || st == HOLDC));
  assign done     = (st == HOLDC) || (st == RECOV && !h_q);
  assign mem_addr = a_q;
  assign mem_dout = d_q;

  // R3
  cs_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> !$past(mem_cs_n));
  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));
  // R6
  cs_trail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (!mem_cs_n ##1 mem_cs_n));
  // R7
  data_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_doe);
  // R2
  busy_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (mem_cs_n && !mem_doe));
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && ready));
  // R10
  strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |=> mem_we_n);
endmodule

// File: tb/wr_strobe_seq_tb.sv
module wr_strobe_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [15:0] req_addr = '0, req_data = '0;
  logic [2:0]  req_wait = '0;
  logic [1:0]  req_mode = '0;
  logic        req_hold = 1'b0;
  logic        ack = 1'b1;
  logic        ready, done, mem_cs_n, mem_we_n, mem_doe;
  logic [15:0] mem_addr, mem_dout;

  int total = 0, bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  wr_strobe_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .req_addr(req_addr), .req_data(req_data),
    .req_wait(req_wait), .req_mode(req_mode), .req_hold(req_hold), .ready(ready),
    .ack(ack), .done(done), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
    .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_doe(mem_doe)
  );

  // behavioural reference: phase 0 idle, 1 setup, 2 strobe, 3 after strobe, 4 hold
  int ph_m = 0, j = 0, e = -1;
  int ma, md, mw, mm, mh;
  bit a1 = 0, a2 = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      ph_m = 0;
    end else begin
      case (ph_m)
        0: if (req) begin
          ma = req_addr; md = req_data; mw = req_wait; mm = req_mode; mh = req_hold;
          ph_m = 1;
        end
        1: begin ph_m = 2; j = 0; e = -1; end
        2: begin
          int minl;
          bit fin;
          minl = 2 * (1 + ((mm == 1) ? 0 : mw));
          if (j % 2 == 0 && a2 && e < 0) e = j;
          fin = (j + 1 >= minl) && (mm == 0 || (e >= 0 && j + 1 >= e + 4));
          if (fin) ph_m = 3; else j++;
        end
        3: ph_m = mh ? 4 : 0;
        default: ph_m = 0;
      endcase
    end
    a2 = a1;
    a1 = ack;
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  int gap = 0;
  bit seen_strobe = 0;
  bit prev_we = 1;
  always @(negedge clk) if (rst_n && !finished) begin
    chk("R2 ready", ready, ph_m == 0);
    chk("R3/R6 cs_n", mem_cs_n, !(ph_m >= 1 && ph_m <= 3));
    chk("R4/R5 we_n", mem_we_n, ph_m != 2);
    chk("R7/R8 doe", mem_doe, ph_m == 2 || (mh && (ph_m == 3 || ph_m == 4)));
    chk("R9 done", done, ph_m == 4 || (ph_m == 3 && !mh));
    if (ph_m >= 1 && ph_m <= 3) chk("R3 addr", mem_addr, ma);
    if (ph_m == 2) chk("R7 data", mem_dout, md);
    if (prev_we && !mem_we_n && seen_strobe) chk("R10 gap", gap >= 2, 1);
    if (!mem_we_n) begin seen_strobe = 1; gap = 0; end else gap++;
    prev_we = mem_we_n;
  end

  task automatic tick(); @(posedge clk); #2; endtask

  task automatic issue(input logic [15:0] a, d, input int w, m, h);
    while (!ready) tick();
    req = 1; req_addr = a; req_data = d; req_wait = w[2:0]; req_mode = m[1:0]; req_hold = h[0];
    tick();
    req = 0;
  endtask

  task automatic settle();
    tick();
    while (!ready) tick();
    tick();
  endtask

  initial begin
    #5;
    chk("R1 cs_n", mem_cs_n, 1);
    chk("R1 we_n", mem_we_n, 1);
    chk("R1 doe", mem_doe, 0);
    chk("R1 done", done, 0);
    chk("R1 ready", ready, 1);
    repeat (3) tick();
    rst_n = 1;
    tick();
    issue(16'h1000, 16'hA001, 0, 0, 0); settle();
    issue(16'h1004, 16'hA002, 3, 0, 1); settle();
    issue(16'h1008, 16'hA003, 7, 0, 0); settle();
    ack = 1; issue(16'h2000, 16'hB001, 5, 1, 0); settle();
    ack = 0; issue(16'h2004, 16'hB002, 0, 1, 1);
    repeat (9) tick(); ack = 1; settle();
    ack = 0; issue(16'h2008, 16'hB003, 5, 2, 0);
    repeat (3) tick(); ack = 1; settle();
    ack = 0; issue(16'h200C, 16'hB004, 1, 2, 1);
    repeat (14) tick(); ack = 1; settle();
    ack = 0; issue(16'h2010, 16'hB005, 2, 3, 0);
    repeat (6) tick(); ack = 1; settle();
    // R2: request raised while busy is refused
    issue(16'h3000, 16'hC001, 4, 0, 0);
    req = 1; req_addr = 16'hDEAD; req_data = 16'hBEEF; req_wait = 0;
    repeat (4) tick();
    req = 0;
    settle();
    repeat (4) tick();
    chk("R2 no extra access", mem_cs_n, 1);
    // back to back
    req = 1; req_addr = 16'h4000; req_data = 16'hD001; req_wait = 0; req_mode = 0; req_hold = 0;
    repeat (12) tick();
    req = 0;
    settle();
    for (int k = 0; k < 8; k++) begin
      issue(16'h5000 + 16'(k), 16'hE000 + 16'(k), k, k % 4, k % 2);
      ack = 1;
      settle();
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #3000000;
    if (!finished) begin
      finished = 1;
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule